// File: doc/BRIEF.md
# Latched Interrupt Error Status Register

This block collects error events reported by the rest of a local interrupt controller. Each error type arrives as a one-cycle strobe and sets a sticky flag in a hidden accumulator. Software cannot see the accumulator directly. A write to the status register copies the accumulated flags into the readable register and empties the accumulator, so software always reads the errors that were gathered up to its last write.

A companion error entry register holds the interrupt vector used for error reporting and a mask bit. When the accumulator goes from empty to holding at least one flag while the entry is unmasked, the block raises a one-cycle interrupt request and presents the entry's vector alongside it.

The block also raises two errors of its own. Writing the entry with a vector of zero is flagged as an illegal vector, whether or not the entry is masked. Any read or write to an address that decodes to no register is flagged as an illegal register access.

Top module: `err_status_unit`

## Requirements
- R1: After a synchronous active-high reset the status register reads 0, the accumulator is empty, the entry reads 0x0001_0000 (masked, vector 0) and `err_irq` is low.
- R2: A strobe on `err_evt[i]` sets sticky accumulator flag i. Flag meanings: bit 0 transmit checksum, bit 1 receive checksum, bit 2 send accept, bit 3 receive accept, bit 5 send illegal vector, bit 6 receive illegal vector, bit 7 illegal register address. A new flag is not visible on a read of address 0 until a later write to address 0.
- R3: A write to address 0 copies the accumulator into the readable status register and clears the accumulator; the write data has no effect.
- R4: An event that arrives in the same cycle as a write to address 0 stays in the accumulator and shows up after the next write to address 0.
- R5: Status bit 4 and bits 31:8 always read 0; `err_evt[4]` has no effect.
- R6: Address 1 is the error entry: bits 7:0 hold the vector, bit 16 the mask (1 = masked), all other bits read 0. Reads are combinational on `reg_addr`.
- R7: A write to address 1 with bits 7:0 equal to zero sets accumulator flag 6, whether or not bit 16 is set in that write.
- R8: A read or write to address 2 or 3 sets accumulator flag 7 and reads 0.
- R9: When the accumulator goes from empty to non-empty (counting one cleared by a write to address 0 in that same cycle as empty) while the entry is unmasked, `err_irq` is high for exactly the next cycle, and `err_irq_vector` shows the entry vector.
- R10: No request is raised while the entry is masked. Unmasking the entry while flags are pending does not raise a request.
- R11: No further request is raised while the accumulator stays non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | 8 | One-cycle error strobes, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address: 0 status, 1 error entry |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| err_irq | output | 1 | Error interrupt request pulse |
| err_irq_vector | output | 8 | Vector from the error entry |

## Verification
The bench goes after the cycle where a status write and a new event coincide. A design that cleared the accumulator after merging the event would lose that error. A design that treated the clear as non-empty would never re-raise the request.

It also checks reads made before the latching write. A design that exposed live flags would show errors too early.

It programs a masked entry with vector zero. A design that gated the illegal-vector check on the mask would miss that error. It then unmasks the entry with flags pending; an edge detector on the mask would fire a spurious request there.

Random traffic mixes these cases with illegal addresses and the unused bit 4 strobe.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
    localparam int DATA_W   = 32;
    localparam int FLAG_W   = 8;
    localparam int VEC_W    = 8;
    localparam int MASK_POS = 16;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_ENTRY  = 1;

    // flag positions that the block raises itself
    localparam int FLG_RX_ILLVEC = 6;
    localparam int FLG_ILLREG    = 7;

    // bits that carry a flag; bit 4 is reserved
    localparam logic [FLAG_W-1:0] FLAG_IMPL = 8'hEF;

    typedef struct packed {
        logic             masked;
        logic [VEC_W-1:0] vector;
    } entry_t;

    typedef struct packed {
        logic wr_status;
        logic wr_entry;
        logic rd_status;
        logic rd_entry;
        logic illegal;
    } access_t;

    function automatic logic [DATA_W-1:0] pack_entry(input entry_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0] = e.vector;
        w[MASK_POS]  = e.masked;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic [FLAG_W-1:0] f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FLAG_W-1:0] = f & FLAG_IMPL;
        return w;
    endfunction
endpackage

// File: rtl/err_stat_decode.sv
module err_stat_decode
    import err_stat_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [VEC_W-1:0]  wr_vector,
    output access_t           access,
    output logic [FLAG_W-1:0] int_evt
);
    logic hit_status;
    logic hit_entry;

    always_comb begin
        hit_status = (reg_addr == ADDR_W'(ADDR_STATUS));
        hit_entry  = (reg_addr == ADDR_W'(ADDR_ENTRY));

        access.wr_status = reg_wr && hit_status;
        access.wr_entry  = reg_wr && hit_entry;
        access.rd_status = reg_rd && hit_status;
        access.rd_entry  = reg_rd && hit_entry;
        access.illegal   = (reg_wr || reg_rd) && !hit_status && !hit_entry;

        int_evt = '0;
        int_evt[FLG_RX_ILLVEC] = access.wr_entry && (wr_vector == '0);
        int_evt[FLG_ILLREG]    = access.illegal;
    end
endmodule

// File: rtl/err_stat_entry.sv
module err_stat_entry
    import err_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] wr_vector,
    input  logic             wr_masked,
    output entry_t           entry
);
    always_ff @(posedge clk) begin
        if (rst) begin
            entry.masked <= 1'b1;
            entry.vector <= '0;
        end else if (wr_en) begin
            entry.masked <= wr_masked;
            entry.vector <= wr_vector;
        end
    end
endmodule

// File: rtl/err_stat_accum.sv
module err_stat_accum
    import err_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  logic [FLAG_W-1:0] evt,
    output logic [FLAG_W-1:0] acc_flags,
    output logic [FLAG_W-1:0] vis_flags,
    output logic              first_evt
);
    logic [FLAG_W-1:0] evt_live;

    assign evt_live = evt & FLAG_IMPL;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (FLAG_IMPL[i]) begin : g_impl
            logic acc_q;
            logic vis_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q <= 1'b0;
                    vis_q <= 1'b0;
                end else begin
                    if (latch)
                        vis_q <= acc_q;
                    acc_q <= (acc_q && !latch) || evt_live[i];
                end
            end
            assign acc_flags[i] = acc_q;
            assign vis_flags[i] = vis_q;
        end else begin : g_rsvd
            assign acc_flags[i] = 1'b0;
            assign vis_flags[i] = 1'b0;
        end
    end

    // accumulator is empty before this cycle's events when cleared now
    assign first_evt = (latch || (acc_flags == '0)) && (evt_live != '0);
endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
    import err_stat_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        err_evt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              err_irq,
    output logic [7:0]        err_irq_vector
);
    access_t           access;
    logic [FLAG_W-1:0] int_evt;
    logic [FLAG_W-1:0] evt_all;
    logic [FLAG_W-1:0] acc_flags;
    logic [FLAG_W-1:0] vis_flags;
    logic              first_evt;
    entry_t            entry;
    logic              irq_q;
    logic              unused_wdata;

    assign unused_wdata = ^{reg_wdata[DATA_W-1:MASK_POS+1], reg_wdata[MASK_POS-1:VEC_W]};

    err_stat_decode #(.ADDR_W(ADDR_W)) u_decode (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .wr_vector (reg_wdata[VEC_W-1:0]),
        .access    (access),
        .int_evt   (int_evt)
    );

    err_stat_entry u_entry (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (access.wr_entry),
        .wr_vector (reg_wdata[VEC_W-1:0]),
        .wr_masked (reg_wdata[MASK_POS]),
        .entry     (entry)
    );

    assign evt_all = err_evt | int_evt;

    err_stat_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .latch     (access.wr_status),
        .evt       (evt_all),
        .acc_flags (acc_flags),
        .vis_flags (vis_flags),
        .first_evt (first_evt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= first_evt && !entry.masked;
    end

    always_comb begin
        if (reg_addr == ADDR_W'(ADDR_STATUS))
            reg_rdata = pack_status(vis_flags);
        else if (reg_addr == ADDR_W'(ADDR_ENTRY))
            reg_rdata = pack_entry(entry);
        else
            reg_rdata = '0;
    end

    assign err_irq        = irq_q;
    assign err_irq_vector = entry.vector;
endmodule

// File: rtl/err_stat_chk.sv
module err_stat_chk
    import err_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input access_t           access,
    input logic [VEC_W-1:0]  wr_vector,
    input logic [FLAG_W-1:0] evt_all,
    input logic [FLAG_W-1:0] acc_flags,
    input logic [FLAG_W-1:0] vis_flags,
    input entry_t            entry,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              err_irq
);
    logic [FLAG_W-1:0] evt_live;
    assign evt_live = evt_all & FLAG_IMPL;

    AST_WRITE_LATCH: assert property (@(posedge clk) disable iff (rst)
        access.wr_status |=> vis_flags == $past(acc_flags)); // R3

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (evt_live != '0) |=> (acc_flags & $past(evt_live)) == $past(evt_live)); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        access.rd_status |-> (reg_rdata[DATA_W-1:FLAG_W] == '0) && !reg_rdata[4]); // R5

    AST_ZERO_VEC: assert property (@(posedge clk) disable iff (rst)
        (access.wr_entry && wr_vector == '0) |=> acc_flags[FLG_RX_ILLVEC]); // R7

    AST_ILLEGAL_ADDR: assert property (@(posedge clk) disable iff (rst)
        access.illegal |=> acc_flags[FLG_ILLREG]); // R8

    AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> $past(!entry.masked)); // R10

    AST_IRQ_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> ($past(acc_flags) == '0) || $past(access.wr_status)); // R11
endmodule

bind err_status_unit err_stat_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .access    (access),
    .wr_vector (reg_wdata[7:0]),
    .evt_all   (evt_all),
    .acc_flags (acc_flags),
    .vis_flags (vis_flags),
    .entry     (entry),
    .reg_rdata (reg_rdata),
    .err_irq   (err_irq)
);

// File: tb/err_status_unit_bench.sv
module err_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  err_evt = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_irq;
    logic [7:0]  err_irq_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_acc, m_vis, m_vec;
    logic       m_mask;

    always #5 clk = ~clk;

    err_status_unit u_err_status_unit (
        .clk            (clk),
        .rst            (rst),
        .err_evt        (err_evt),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .err_irq        (err_irq),
        .err_irq_vector (err_irq_vector)
    );

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        if (a == 2'd0) return {24'h0, m_vis};
        if (a == 2'd1) return {15'h0, m_mask, 8'h0, m_vec};
        return 32'h0;
    endfunction

    function automatic logic [7:0] exp_evt(input logic wr, input logic rd,
                                           input logic [1:0] a, input logic [31:0] wd,
                                           input logic [7:0] ev);
        logic [7:0] e;
        e = ev & 8'hEF;
        if (wr && a == 2'd1 && wd[7:0] == 8'h0) e[6] = 1'b1;
        if ((wr || rd) && a >= 2'd2) e[7] = 1'b1;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_acc = '0; m_vis = '0; m_vec = '0; m_mask = 1'b1;
    endtask

    // one bus cycle: inputs driven after a falling edge, results checked at the next one
    task automatic op(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [31:0] wd, input logic [7:0] ev);
        logic [7:0] eff, base;
        logic       exp_irq;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; err_evt = ev;
        #1;
        if (rd) chk({cur_req, " read"}, reg_rdata, exp_rdata(a));
        eff  = exp_evt(wr, rd, a, wd, ev);
        base = (wr && a == 2'd0) ? 8'h0 : m_acc;
        exp_irq = (base == 8'h0) && (eff != 8'h0) && !m_mask;
        if (wr && a == 2'd0) m_vis = m_acc;
        m_acc = base | eff;
        if (wr && a == 2'd1) begin
            m_vec  = wd[7:0];
            m_mask = wd[16];
        end
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; err_evt = '0;
        chk({cur_req, " irq"}, {31'h0, err_irq}, {31'h0, exp_irq});
        if (exp_irq) chk({cur_req, " irq vector"}, {24'h0, err_irq_vector}, {24'h0, m_vec});
    endtask

    task automatic latch_and_read();
        op(1'b1, 1'b0, 2'd0, 32'hFFFF_FFFF, 8'h0);
        op(1'b0, 1'b1, 2'd0, 32'h0, 8'h0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        cur_req = "R1";
        chk("R1 status after reset", reg_rdata, 32'h0);
        chk("R1 irq after reset", {31'h0, err_irq}, 32'h0);
        op(1'b0, 1'b1, 2'd1, 32'h0, 8'h0);

        cur_req = "R2";
        op(1'b0, 1'b0, 2'd0, 32'h0, 8'h04);
        op(1'b0, 1'b1, 2'd0, 32'h0, 8'h0);

        cur_req = "R6";
        op(1'b1, 1'b0, 2'd1, 32'hFFFE_0033, 8'h0);
        op(1'b0, 1'b1, 2'd1, 32'h0, 8'h0);

        cur_req = "R3";
        latch_and_read();

        cur_req = "R9";
        op(1'b0, 1'b0, 2'd0, 32'h0, 8'h20);

        cur_req = "R11";
        op(1'b0, 1'b0, 2'd0, 32'h0, 8'h08);
        op(1'b0, 1'b0, 2'd0, 32'h0, 8'h02);

        cur_req = "R4";
        op(1'b1, 1'b0, 2'd0, 32'h0, 8'h01);
        op(1'b0, 1'b1, 2'd0, 32'h0, 8'h0);
        latch_and_read();

        cur_req = "R5";
        latch_and_read();
        op(1'b0, 1'b0, 2'd0, 32'h0, 8'h10);
        latch_and_read();

        cur_req = "R7";
        op(1'b1, 1'b0, 2'd1, 32'h0001_0000, 8'h0);
        latch_and_read();

        cur_req = "R8";
        op(1'b0, 1'b1, 2'd2, 32'h0, 8'h0);
        op(1'b1, 1'b0, 2'd3, 32'h1234_5678, 8'h0);
        latch_and_read();

        cur_req = "R10";
        op(1'b1, 1'b0, 2'd1, 32'h0001_0055, 8'h0);
        latch_and_read();
        latch_and_read();
        op(1'b0, 1'b0, 2'd0, 32'h0, 8'h80);
        op(1'b1, 1'b0, 2'd1, 32'h0000_0055, 8'h0);
        op(1'b0, 1'b0, 2'd0, 32'h0, 8'h01);
        latch_and_read();

        cur_req = "R9 random";
        for (int n = 0; n < 3000; n++) begin
            int unsigned kind;
            logic [7:0]  ev;
            logic [31:0] wd;
            kind = $urandom_range(0, 9);
            ev   = ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h0;
            wd   = $urandom();
            case (kind)
                0, 1: op(1'b1, 1'b0, 2'd0, wd, ev);
                2, 3: op(1'b0, 1'b1, 2'd0, wd, ev);
                4: begin
                    if ($urandom_range(0, 3) == 0) wd[7:0] = 8'h0;
                    op(1'b1, 1'b0, 2'd1, wd, ev);
                end
                5: op(1'b0, 1'b1, 2'd1, wd, ev);
                6: op($urandom_range(0, 1) == 1, 1'b1, 2'($urandom_range(2, 3)), wd, ev);
                default: op(1'b0, 1'b0, 2'd0, wd, ev);
            endcase
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog during %s: actual hung expected finished", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule